// File: doc/BRIEF.md
# GPIO Bank with Port-Level Wake on Change

This block controls a bank of general-purpose pins arranged as 4-bit ports. There are six push-pull ports, giving 24 pins, and one open-drain port of 3 pins, for 27 pins in all. Software sets up the pins through a small register interface. It chooses the direction of each pin and the value each output drives. It can turn on a pull-up or a pull-down on the pins of one designated port. It chooses which ports can wake the system. It can read back the synchronized pin levels.

The block drives per-pin output-enable and data signals toward the pads, and per-pin pull controls for the designated port. While the system sits in a stop or wait state, shown by `low_power`, a level change on an input pin of a wake-enabled port raises a one-cycle `wake_pulse`. The same event sets a sticky status bit that software clears by writing 1.

The asynchronous active-low reset is released synchronously inside the block. With the default parameters, pin i (0 to 26) belongs to port i/4. The designated pull port is port 5 (pins 20 to 23), and the open-drain port is port 6 (pins 24 to 26).

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset, every `pin_oe` bit is 0, both pull outputs are 0, `wake_pulse` is 0, and the direction, output, pull, wake-enable and status registers all read back 0.
- R2: On push-pull pins 0 to 23, `pin_oe[i]` equals the direction bit (1 means output) and `pin_do[i]` equals the output-data bit. A pin set as input has `pin_oe[i]` = 0.
- R3: On open-drain pins 24 to 26, `pin_do[i]` is always 0. `pin_oe[i]` is 1 only when the pin is an output whose data bit is 0, so writing 1 lets the pin float.
- R4: For the pull port, with pull register bits [3:0] as enables and bits [7:4] as polarity (1 = up, 0 = down), `pull_up_o[j]` is enable & polarity & input and `pull_dn_o[j]` is enable & ~polarity & input, for pin 20+j. A pin set as output gets no pull, and both pulls are never active together.
- R5: Reading address 4 returns the pin levels at bits [26:0] through a two-flop synchronizer. A change at `pin_di` becomes visible after the second rising edge and not after the first.
- R6: With `low_power` = 1, a level change on an input pin whose port has its wake-enable bit set makes `wake_pulse` high for exactly one cycle, after the third rising edge that follows the change.
- R7: No wake pulse and no status change occur when `low_power` is 0, when the pin's port is not wake-enabled, or when the pin is configured as an output.
- R8: The sticky status (address 5, bit 0) is set with every wake pulse. Writing 1 to bit 0 clears it, and writing 0 leaves it set. When a new wake event and a clearing write fall on the same edge, the status stays set.
- R9: The register map uses these addresses: 0 direction, 1 output data, 2 pull control, 3 wake enable (bits [6:0], one per port), 4 pin levels (read only), 5 status. Writable registers read back the value written, and writes to address 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_di | input | 27 | Levels seen at the pins |
| low_power | input | 1 | System is in stop or wait state |
| pin_oe | output | 27 | Per-pin output enable |
| pin_do | output | 27 | Per-pin drive value |
| pull_up_o | output | 4 | Pull-up enables for the pull port |
| pull_dn_o | output | 4 | Pull-down enables for the pull port |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
A wake event can set the sticky status on the same edge that a software write of 1 tries to clear it. The bench provokes this by toggling a pin on a wake-enabled port and timing the clearing write so that it lands on the third edge after the change, the edge where the event registers. The collision is judged correct if the status still reads 1 afterwards and is then cleared by a second, lone write.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned GRP_W  = 4;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 3'd0,
    A_OUT  = 3'd1,
    A_PULL = 3'd2,
    A_WAKE = 3'd3,
    A_PIN  = 3'd4,
    A_STS  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync_detect.sv
module gpio_sync_detect #(
  parameter int unsigned NPINS = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_di,
  output logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] pin_chg
);
  logic [NPINS-1:0] meta_q, sync_q, prev_q;
  logic [NPINS-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pin_di;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign pin_sync = sync_q;
  assign pin_chg  = sync_q ^ prev_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NPINS  = 27,
  parameter int unsigned NPORTS = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPINS-1:0]  pin_sync,
  input  logic              wake_sts,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [GRP_W-1:0]  pull_en_q,
  output logic [GRP_W-1:0]  pull_up_q,
  output logic [NPORTS-1:0] wake_en_q,
  output logic              sts_clr,
  output logic [DATA_W-1:0] rdata
);
  logic [NPINS-1:0]  dir_d, out_d;
  logic [GRP_W-1:0]  pull_en_d, pull_up_d;
  logic [NPORTS-1:0] wake_en_d;

  always_comb begin
    dir_d     = dir_q;
    out_d     = out_q;
    pull_en_d = pull_en_q;
    pull_up_d = pull_up_q;
    wake_en_d = wake_en_q;
    sts_clr   = 1'b0;
    if (we) begin
      case (reg_addr_e'(addr))
        A_DIR:  dir_d = wdata[NPINS-1:0];
        A_OUT:  out_d = wdata[NPINS-1:0];
        A_PULL: begin
          pull_en_d = wdata[GRP_W-1:0];
          pull_up_d = wdata[2*GRP_W-1:GRP_W];
        end
        A_WAKE: wake_en_d = wdata[NPORTS-1:0];
        A_STS:  sts_clr = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      out_q     <= '0;
      pull_en_q <= '0;
      pull_up_q <= '0;
      wake_en_q <= '0;
    end else begin
      dir_q     <= dir_d;
      out_q     <= out_d;
      pull_en_q <= pull_en_d;
      pull_up_q <= pull_up_d;
      wake_en_q <= wake_en_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_DIR:  rdata[NPINS-1:0] = dir_q;
      A_OUT:  rdata[NPINS-1:0] = out_q;
      A_PULL: begin
        rdata[GRP_W-1:0]       = pull_en_q;
        rdata[2*GRP_W-1:GRP_W] = pull_up_q;
      end
      A_WAKE: rdata[NPORTS-1:0] = wake_en_q;
      A_PIN:  rdata[NPINS-1:0] = pin_sync;
      A_STS:  rdata[0] = wake_sts;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NPP        = 24,
  parameter int unsigned NOD        = 3,
  parameter int unsigned PULL_GROUP = 5,
  localparam int unsigned NPINS     = NPP + NOD,
  localparam int unsigned PBASE     = PULL_GROUP * GRP_W
) (
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] out_q,
  input  logic [GRP_W-1:0] pull_en_q,
  input  logic [GRP_W-1:0] pull_up_q,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_do,
  output logic [GRP_W-1:0] pull_up_o,
  output logic [GRP_W-1:0] pull_dn_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i < NPP) begin : g_pp
      assign pin_oe[i] = dir_q[i];
      assign pin_do[i] = out_q[i];
    end else begin : g_od
      assign pin_oe[i] = dir_q[i] & ~out_q[i];
      assign pin_do[i] = 1'b0;
    end
  end

  for (genvar j = 0; j < GRP_W; j++) begin : g_pull
    assign pull_up_o[j] = pull_en_q[j] &  pull_up_q[j] & ~dir_q[PBASE+j];
    assign pull_dn_o[j] = pull_en_q[j] & ~pull_up_q[j] & ~dir_q[PBASE+j];
  end
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NPINS  = 27,
  parameter int unsigned NPORTS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_chg,
  input  logic [NPINS-1:0]  dir_q,
  input  logic [NPORTS-1:0] wake_en_q,
  input  logic              low_power,
  input  logic              sts_clr,
  output logic              wake_pulse,
  output logic              wake_sts
);
  logic [NPINS-1:0] pin_wen;
  logic [NPINS-1:0] evt;
  logic             pulse_d, sts_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_wen
    assign pin_wen[i] = wake_en_q[i / GRP_W];
  end

  always_comb begin
    evt     = pin_chg & ~dir_q & pin_wen & {NPINS{low_power}};
    pulse_d = |evt;
    sts_d   = pulse_d | (wake_sts & ~sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_pulse <= 1'b0;
      wake_sts   <= 1'b0;
    end else begin
      wake_pulse <= pulse_d;
      wake_sts   <= sts_d;
    end
  end

  AST_PULSE_NEEDS_LP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(low_power)); // R7
  AST_PULSE_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> wake_sts); // R8
  AST_STS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sts && !sts_clr) |=> wake_sts); // R8
endmodule

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank
  import gpio_wake_pkg::*;
#(
  parameter int unsigned PP_GROUPS  = 6,
  parameter int unsigned OD_PINS    = 3,
  parameter int unsigned PULL_GROUP = 5,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned NPP       = PP_GROUPS * GRP_W,
  localparam int unsigned NPINS     = NPP + OD_PINS,
  localparam int unsigned NPORTS    = PP_GROUPS + (OD_PINS + GRP_W - 1) / GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPINS-1:0]  pin_di,
  input  logic              low_power,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_do,
  output logic [GRP_W-1:0]  pull_up_o,
  output logic [GRP_W-1:0]  pull_dn_o,
  output logic              wake_pulse
);
  logic rst_m_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_ns  <= rst_m_q;
    end
  end

  logic [NPINS-1:0]  pin_sync, pin_chg, dir_q, out_q;
  logic [GRP_W-1:0]  pull_en_q, pull_up_q;
  logic [NPORTS-1:0] wake_en_q;
  logic              sts_clr, wake_sts;

  gpio_sync_detect #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_ns), .pin_di(pin_di),
    .pin_sync(pin_sync), .pin_chg(pin_chg)
  );

  gpio_regs #(.NPINS(NPINS), .NPORTS(NPORTS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_ns), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .pin_sync(pin_sync), .wake_sts(wake_sts), .dir_q(dir_q), .out_q(out_q),
    .pull_en_q(pull_en_q), .pull_up_q(pull_up_q), .wake_en_q(wake_en_q),
    .sts_clr(sts_clr), .rdata(reg_rdata)
  );

  gpio_pad_ctrl #(.NPP(NPP), .NOD(OD_PINS), .PULL_GROUP(PULL_GROUP)) u_pad (
    .dir_q(dir_q), .out_q(out_q), .pull_en_q(pull_en_q), .pull_up_q(pull_up_q),
    .pin_oe(pin_oe), .pin_do(pin_do), .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o)
  );

  gpio_wake #(.NPINS(NPINS), .NPORTS(NPORTS)) u_wake (
    .clk(clk), .rst_n(rst_ns), .pin_chg(pin_chg), .dir_q(dir_q),
    .wake_en_q(wake_en_q), .low_power(low_power), .sts_clr(sts_clr),
    .wake_pulse(wake_pulse), .wake_sts(wake_sts)
  );

  AST_OE_ONLY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_ns)
    (pin_oe & ~dir_q) == '0); // R2
  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_ns)
    (pull_up_o & pull_dn_o) == '0); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_ns |-> (pin_oe == '0 && !wake_pulse)); // R1
endmodule

// File: tb/sim_gpio_wake_bank.sv
module sim_gpio_wake_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [26:0] pin_di;
  logic        low_power;
  logic [26:0] pin_oe, pin_do;
  logic [3:0]  pull_up_o, pull_dn_o;
  logic        wake_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_wake_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_di(pin_di),
    .low_power(low_power), .pin_oe(pin_oe), .pin_do(pin_do),
    .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o), .wake_pulse(wake_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wake_try(input int pin, input bit expect_evt, input string req);
    int cnt = 0;
    int first = -1;
    logic [31:0] v;
    @(negedge clk);
    pin_di[pin] = ~pin_di[pin];
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (wake_pulse) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
    if (expect_evt) begin
      check(cnt == 1, req, cnt, 1);
      check(first == 3, req, first, 3);
      rd(3'd5, v);
      check(v == 32'd1, "R8", v, 1);
      wr(3'd5, 32'd1);
      rd(3'd5, v);
      check(v == 32'd0, "R8", v, 0);
    end else begin
      check(cnt == 0, req, cnt, 0);
      rd(3'd5, v);
      check(v == 32'd0, req, v, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [26:0] ed, eo, exp_oe, exp_do;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_di = '0; low_power = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(pin_oe == '0, "R1", 32'(pin_oe), 0);
    check(pull_up_o == '0 && pull_dn_o == '0, "R1", {pull_up_o, pull_dn_o}, 0);
    check(!wake_pulse, "R1", 32'(wake_pulse), 0);
    for (int a = 0; a < 6; a++) begin
      if (a != 4) begin
        rd(3'(a), v);
        check(v == 0, "R1", v, 0);
      end
    end

    // R2 R3 R9 direction/output sweep, per group, all nibble patterns
    for (int g = 0; g < 7; g++) begin
      for (int p = 0; p < 256; p++) begin
        ed = 27'(32'(p & 15) << (4 * g));
        eo = 27'(32'((p >> 4) & 15) << (4 * g));
        wr(3'd0, 32'(ed));
        wr(3'd1, 32'(eo));
        for (int i = 0; i < 27; i++) begin
          if (i < 24) begin
            exp_oe[i] = ed[i]; exp_do[i] = eo[i];
          end else begin
            exp_oe[i] = ed[i] & ~eo[i]; exp_do[i] = 1'b0;
          end
        end
        check(pin_oe == exp_oe, (g == 6) ? "R3" : "R2", 32'(pin_oe), 32'(exp_oe));
        check(pin_do == exp_do, (g == 6) ? "R3" : "R2", 32'(pin_do), 32'(exp_do));
        rd(3'd0, v);
        check(v == 32'(ed), "R9", v, 32'(ed));
      end
    end
    wr(3'd1, 32'd0);

    // R4 pull sweep: enable x polarity x direction on pins 20..23
    for (int c = 0; c < 4096; c++) begin
      logic [3:0] en, up, dn;
      en = 4'(c); up = 4'(c >> 4); dn = 4'(c >> 8);
      wr(3'd2, 32'({up, en}));
      wr(3'd0, 32'(dn) << 20);
      check(pull_up_o == (en & up & ~dn), "R4", 32'(pull_up_o), 32'(en & up & ~dn));
      check(pull_dn_o == (en & ~up & ~dn), "R4", 32'(pull_dn_o), 32'(en & ~up & ~dn));
    end
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd0);

    // R5 readback through synchronizer; R9 write to address 4 ignored
    for (int t = 0; t < 4; t++) begin
      logic [26:0] oldv, newv;
      oldv = pin_di;
      newv = 27'(32'h5A5A_3C3C * (t + 1) + 32'(t));
      pin_di = newv;
      @(negedge clk);
      rd(3'd4, v);
      check(v == 32'(oldv), "R5", v, 32'(oldv));
      @(negedge clk);
      rd(3'd4, v);
      check(v == 32'(newv), "R5", v, 32'(newv));
    end
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v);
    check(v == 32'(pin_di), "R9", v, 32'(pin_di));
    pin_di = '0;
    repeat (4) @(negedge clk);

    // R6 wake on each pin, all ports enabled
    low_power = 1'b1;
    wr(3'd3, 32'h7F);
    rd(3'd3, v);
    check(v == 32'h7F, "R9", v, 32'h7F);
    for (int i = 0; i < 27; i++) begin
      wake_try(i, 1'b1, "R6");
    end

    // R7 blocked cases
    for (int i = 0; i < 27; i++) begin
      wr(3'd3, 32'h7F & ~(32'd1 << (i / 4)));
      wake_try(i, 1'b0, "R7");
      wr(3'd3, 32'h7F);
      wr(3'd0, 32'd1 << i);
      wake_try(i, 1'b0, "R7");
      wr(3'd0, 32'd0);
      low_power = 1'b0;
      wake_try(i, 1'b0, "R7");
      low_power = 1'b1;
    end

    // R8 write of 0 does not clear
    wake_try(5, 1'b1, "R6");
    @(negedge clk);
    pin_di[9] = ~pin_di[9];
    repeat (8) @(negedge clk);
    wr(3'd5, 32'd0);
    rd(3'd5, v);
    check(v == 32'd1, "R8", v, 1);
    wr(3'd5, 32'd1);
    rd(3'd5, v);
    check(v == 32'd0, "R8", v, 0);

    // R8 set and clear on the same edge: set wins
    for (int i = 0; i < 27; i += 4) begin
      @(negedge clk);
      pin_di[i] = ~pin_di[i];
      @(negedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd1;
      @(negedge clk);
      reg_we = 1'b0;
      check(wake_pulse, "R8", 32'(wake_pulse), 1);
      rd(3'd5, v);
      check(v == 32'd1, "R8", v, 1);
      repeat (3) @(negedge clk);
      wr(3'd5, 32'd1);
      rd(3'd5, v);
      check(v == 32'd0, "R8", v, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule